// File: doc/BRIEF.md
# ADC Result Bank with Interrupt

This block sits behind an analog-to-digital converter sequencer and stores what it produces. Each completion event carries a channel number and a 10-bit sample. The block writes the sample into that channel's result register and also into one shared "latest result" register, which records the source channel as well. Every result register has a done flag and an overrun flag. A status word gathers all per-channel flags. An interrupt line is raised from per-channel enable bits, and from a global enable that follows the shared done flag.

Software reaches the block through a plain register port. A read of a result register is a clearing read: the data returned shows the flags as they were, and the flags drop on the same edge. A separate control-clear pulse, raised when the converter's control register is written, clears the shared done flag. Completion events arrive on a valid/ready stream. The block never pushes back, so `cmp_ready` is held at 1 out of reset and every cycle with `cmp_valid` high is one accepted event.

Top module: `adcrb_bank`

## Requirements
- R1: After reset all done and overrun flags are 0, the interrupt enable word (address 10) reads 0x00000100 (channel enables 0, global enable 1), `irq` is 0, and `cmp_ready` is 1.
- R2: An accepted completion for channel c sets that channel's done flag. It stores the sample in that channel's register (address c, 0..7), which reads as sample in bits 15:6, overrun in bit 30, done in bit 31 and all other bits 0.
- R3: Each accepted completion also loads the shared register (address 8): sample in bits 15:6, source channel in bits 26:24, overrun in bit 30, done in bit 31.
- R4: A read of channel register c returns the flags as they were before the read, and clears that channel's done and overrun flags on the read cycle. The stored sample is kept.
- R5: The shared done and overrun flags clear on a read of address 8 or on a `ctl_clr` pulse. The sample and the channel field are kept.
- R6: With `burst_en` = 1, a completion that lands on a register whose done flag is still set sets that register's overrun flag.
- R7: With `burst_en` = 0, a completion does not set the overrun flag. A completion that finds the register already read (done = 0) leaves overrun at 0.
- R8: If a completion and a clearing read hit the same register in the same cycle, the read returns the old contents, and afterwards done is 1 with the new sample and overrun is 0.
- R9: Address 9 reads the status word: per-channel done flags in bits 7:0, per-channel overrun flags in bits 15:8, and in bit 16 the OR over channels of (done AND channel enable). Reading it changes no flag.
- R10: A write to address 10 stores channel enables from bits 7:0 and the global enable from bit 8. Other data bits and writes to any other address have no effect.
- R11: `irq` is a register that, one cycle after the flags change, equals the status bit 16 condition OR (global enable AND shared done).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_en | input | 1 | Burst mode: enables overrun detection |
| cmp_valid | input | 1 | Completion event valid |
| cmp_ready | output | 1 | Completion event ready, always 1 after reset |
| cmp_ch | input | 3 | Channel of the completion |
| cmp_data | input | 10 | Conversion sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clearing reads) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid combinationally during the strobe cycle |
| ctl_clr | input | 1 | Control-write pulse, clears the shared done flag |
| irq | output | 1 | Registered interrupt level |

## Verification
The hardest case to reach is the collision: a completion and a clearing read on the same channel in the same cycle, while done is already set in burst mode. This is where the clear and set priorities, and the overrun decision, all meet. The bench reaches it with a combined driver step that raises `cmp_valid` and `reg_rd` in the same cycle. It then reads the register again to show that done survived with the new sample and that overrun stayed clear. Overrun on the shared register is reached the same way, by sending two completions with no read of address 8 between them.

// File: rtl/adcrb_pkg.sv
package adcrb_pkg;
  localparam int WORD_W      = 32;
  localparam int RES_LSB     = 6;
  localparam int SRC_LSB     = 24;
  localparam int OVR_BIT     = 30;
  localparam int DONE_BIT    = 31;
  localparam int ST_OVR_LSB  = 8;
  localparam int ST_FLAG_BIT = 16;
  localparam int ADDR_W      = 4;
endpackage

// File: rtl/adcrb_slot.sv
// One result register with done/overrun tracking.
module adcrb_slot #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_en,
  input  logic             load,
  input  logic [RES_W-1:0] load_res,
  input  logic [CH_W-1:0]  load_ch,
  input  logic             clr,
  output logic             done,
  output logic             ovr,
  output logic [RES_W-1:0] res,
  output logic [CH_W-1:0]  src
);
  // state as seen by a completion arriving together with a clear
  logic done_left;
  logic ovr_left;

  always_comb begin
    done_left = done & ~clr;
    ovr_left  = ovr  & ~clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      ovr  <= 1'b0;
      res  <= '0;
      src  <= '0;
    end else if (load) begin
      res  <= load_res;
      src  <= load_ch;
      done <= 1'b1;
      ovr  <= done_left & (ovr_left | burst_en);
    end else if (clr) begin
      done <= 1'b0;
      ovr  <= 1'b0;
    end
  end
endmodule

// File: rtl/adcrb_irq.sv
// Interrupt enable word and registered interrupt level.
module adcrb_irq #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_wr,
  input  logic [NCH:0]   en_wdata,
  input  logic [NCH-1:0] chan_done,
  input  logic           g_done,
  output logic [NCH-1:0] en_mask,
  output logic           g_en,
  output logic           chan_flag,
  output logic           irq
);
  always_comb chan_flag = |(chan_done & en_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask <= '0;
      g_en    <= 1'b1;
      irq     <= 1'b0;
    end else begin
      if (en_wr) begin
        en_mask <= en_wdata[NCH-1:0];
        g_en    <= en_wdata[NCH];
      end
      irq <= chan_flag | (g_en & g_done);
    end
  end
endmodule

// File: rtl/adcrb_readmux.sv
// Forms the read word for the addressed register.
module adcrb_readmux
  import adcrb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    chan_done,
  input  logic [NCH-1:0]    chan_ovr,
  input  logic [RES_W-1:0]  chan_res [NCH],
  input  logic              g_done,
  input  logic              g_ovr,
  input  logic [RES_W-1:0]  g_res,
  input  logic [CH_W-1:0]   g_src,
  input  logic [NCH-1:0]    en_mask,
  input  logic              g_en,
  input  logic              chan_flag,
  output logic [WORD_W-1:0] rdata
);
  localparam int A_GLOBAL = NCH;
  localparam int A_STATUS = NCH + 1;
  localparam int A_IRQEN  = NCH + 2;

  logic [WORD_W-1:0] chan_word [NCH];
  logic [WORD_W-1:0] g_word;
  logic [WORD_W-1:0] st_word;
  logic [WORD_W-1:0] en_word;

  for (genvar i = 0; i < NCH; i++) begin : g_word_build
    always_comb begin
      chan_word[i] = '0;
      chan_word[i][RES_LSB +: RES_W] = chan_res[i];
      chan_word[i][OVR_BIT]          = chan_ovr[i];
      chan_word[i][DONE_BIT]         = chan_done[i];
    end
  end

  always_comb begin
    g_word = '0;
    g_word[RES_LSB +: RES_W] = g_res;
    g_word[SRC_LSB +: CH_W]  = g_src;
    g_word[OVR_BIT]          = g_ovr;
    g_word[DONE_BIT]         = g_done;

    st_word = '0;
    st_word[0 +: NCH]          = chan_done;
    st_word[ST_OVR_LSB +: NCH] = chan_ovr;
    st_word[ST_FLAG_BIT]       = chan_flag;

    en_word = '0;
    en_word[0 +: NCH] = en_mask;
    en_word[NCH]      = g_en;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(i)) rdata = chan_word[i];
    end
    if (addr == ADDR_W'(A_GLOBAL)) rdata = g_word;
    if (addr == ADDR_W'(A_STATUS)) rdata = st_word;
    if (addr == ADDR_W'(A_IRQEN))  rdata = en_word;
  end
endmodule

// File: rtl/adcrb_bank.sv
module adcrb_bank
  import adcrb_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_en,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [CH_W-1:0]   cmp_ch,
  input  logic [RES_W-1:0]  cmp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              ctl_clr,
  output logic              irq
);
  localparam int A_GLOBAL = NCH;
  localparam int A_IRQEN  = NCH + 2;

  logic             cmp_fire;
  logic [NCH-1:0]   chan_done;
  logic [NCH-1:0]   chan_ovr;
  logic [RES_W-1:0] chan_res [NCH];
  logic [CH_W-1:0]  chan_src [NCH];
  logic             g_done;
  logic             g_ovr;
  logic [RES_W-1:0] g_res;
  logic [CH_W-1:0]  g_src;
  logic             g_clr;
  logic [NCH-1:0]   en_mask;
  logic             g_en;
  logic             chan_flag;

  // no back-pressure: every valid beat is taken once out of reset
  always_ff @(posedge clk) begin
    if (!rst_n) cmp_ready <= 1'b0;
    else        cmp_ready <= 1'b1;
  end

  always_comb cmp_fire = cmp_valid & cmp_ready;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic ld;
    logic cl;
    always_comb begin
      ld = cmp_fire && (cmp_ch == CH_W'(i));
      cl = reg_rd && (reg_addr == ADDR_W'(i));
    end
    adcrb_slot #(.RES_W(RES_W), .CH_W(CH_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .burst_en (burst_en),
      .load     (ld),
      .load_res (cmp_data),
      .load_ch  (cmp_ch),
      .clr      (cl),
      .done     (chan_done[i]),
      .ovr      (chan_ovr[i]),
      .res      (chan_res[i]),
      .src      (chan_src[i])
    );
  end

  always_comb g_clr = ctl_clr | (reg_rd && (reg_addr == ADDR_W'(A_GLOBAL)));

  adcrb_slot #(.RES_W(RES_W), .CH_W(CH_W)) u_global (
    .clk      (clk),
    .rst_n    (rst_n),
    .burst_en (burst_en),
    .load     (cmp_fire),
    .load_res (cmp_data),
    .load_ch  (cmp_ch),
    .clr      (g_clr),
    .done     (g_done),
    .ovr      (g_ovr),
    .res      (g_res),
    .src      (g_src)
  );

  logic en_wr;
  always_comb en_wr = reg_wr && (reg_addr == ADDR_W'(A_IRQEN));

  adcrb_irq #(.NCH(NCH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_wdata  (reg_wdata[NCH:0]),
    .chan_done (chan_done),
    .g_done    (g_done),
    .en_mask   (en_mask),
    .g_en      (g_en),
    .chan_flag (chan_flag),
    .irq       (irq)
  );

  adcrb_readmux #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_rmux (
    .addr      (reg_addr),
    .chan_done (chan_done),
    .chan_ovr  (chan_ovr),
    .chan_res  (chan_res),
    .g_done    (g_done),
    .g_ovr     (g_ovr),
    .g_res     (g_res),
    .g_src     (g_src),
    .en_mask   (en_mask),
    .g_en      (g_en),
    .chan_flag (chan_flag),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/adcrb_bank_chk.sv
module adcrb_bank_chk #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 4,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic              cmp_ready,
  input logic [CH_W-1:0]   cmp_ch,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              ctl_clr,
  input logic              burst_en,
  input logic [NCH-1:0]    chan_done,
  input logic [NCH-1:0]    chan_ovr,
  input logic              g_done,
  input logic              g_en,
  input logic              irq
);
  // R2
  chan_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready) |=> chan_done[$past(cmp_ch)]);

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr < ADDR_W'(NCH)) &&
     !(cmp_valid && (ADDR_W'(cmp_ch) == reg_addr)))
    |=> !chan_done[$past(reg_addr[CH_W-1:0])]);

  // R5
  ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr && !cmp_valid) |=> !g_done);

  // R7
  no_burst_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_en && cmp_valid && cmp_ready && !chan_ovr[cmp_ch])
    |=> !chan_ovr[$past(cmp_ch)]);

  // R6
  ovr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_ovr & ~chan_done) == '0));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_done == '0) && !g_done) |=> !irq);

  // R11
  irq_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_done && g_en) |=> irq);
endmodule

bind adcrb_bank adcrb_bank_chk #(.NCH(NCH), .ADDR_W(adcrb_pkg::ADDR_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_ready (cmp_ready),
  .cmp_ch    (cmp_ch),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .ctl_clr   (ctl_clr),
  .burst_en  (burst_en),
  .chan_done (chan_done),
  .chan_ovr  (chan_ovr),
  .g_done    (g_done),
  .g_en      (g_en),
  .irq       (irq)
);

// File: tb/adcrb_bank_bench.sv
module adcrb_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_en = 1'b0;
  logic        cmp_valid = 1'b0;
  logic        cmp_ready;
  logic [2:0]  cmp_ch = '0;
  logic [9:0]  cmp_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ctl_clr = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adcrb_bank u_adcrb_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .burst_en  (burst_en),
    .cmp_valid (cmp_valid),
    .cmp_ready (cmp_ready),
    .cmp_ch    (cmp_ch),
    .cmp_data  (cmp_data),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctl_clr   (ctl_clr),
    .irq       (irq)
  );

  // monitor: compare read data against scoreboard on each read strobe
  always @(negedge clk) begin
    if (reg_rd) begin
      rd_item_t it;
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL read with empty scoreboard addr=%0d act=%h exp=none", reg_addr, reg_rdata);
      end else begin
        it = expq.pop_front();
        if (reg_rdata !== it.exp || reg_addr !== it.addr) begin
          errors++;
          $display("FAIL %s addr=%0d act=%h exp=%h", it.tag, it.addr, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    expq.push_back('{addr: a, exp: e, tag: tag});
    reg_addr = a;
    reg_rd   = 1'b1;
    tick();
    reg_rd   = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
    reg_wr    = 1'b0;
  endtask

  task automatic conv(input logic [2:0] c, input logic [9:0] d);
    cmp_ch    = c;
    cmp_data  = d;
    cmp_valid = 1'b1;
    tick();
    cmp_valid = 1'b0;
  endtask

  // completion and clearing read on the same cycle
  task automatic conv_and_rd(input logic [2:0] c, input logic [9:0] d,
                             input logic [31:0] e, input string tag);
    expq.push_back('{addr: {1'b0, c}, exp: e, tag: tag});
    cmp_ch    = c;
    cmp_data  = d;
    cmp_valid = 1'b1;
    reg_addr  = {1'b0, c};
    reg_rd    = 1'b1;
    tick();
    cmp_valid = 1'b0;
    reg_rd    = 1'b0;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, e);
    end
  endtask

  function automatic logic [31:0] cw(input logic d, input logic o, input logic [9:0] r);
    return {d, o, 14'd0, r, 6'd0};
  endfunction

  function automatic logic [31:0] gw(input logic d, input logic o, input logic [2:0] c,
                                     input logic [9:0] r);
    return {d, o, 3'd0, c, 8'd0, r, 6'd0};
  endfunction

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk_bit(irq, 1'b0, "R1 irq after reset");
    chk_bit(cmp_ready, 1'b1, "R1 ready");
    rd(4'd9, 32'h0, "R1 status after reset");
    rd(4'd10, 32'h0000_0100, "R1 enable reset value");

    // R2 R3 single completion, global interrupt path
    conv(3'd3, 10'h2A5);
    tick();
    chk_bit(irq, 1'b1, "R11 irq from global done");
    rd(4'd8, gw(1'b1, 1'b0, 3'd3, 10'h2A5), "R3 global word");
    tick();
    chk_bit(irq, 1'b0, "R11 irq drops after global read");
    rd(4'd9, 32'h0000_0008, "R9 status ch3 done");
    rd(4'd3, cw(1'b1, 1'b0, 10'h2A5), "R2 channel word");
    rd(4'd3, cw(1'b0, 1'b0, 10'h2A5), "R4 cleared by read, sample kept");

    // R6 burst overrun on channel and global
    burst_en = 1'b1;
    conv(3'd5, 10'h111);
    conv(3'd5, 10'h222);
    rd(4'd9, 32'h0000_2020, "R9 status done and overrun");
    rd(4'd8, gw(1'b1, 1'b1, 3'd5, 10'h222), "R6 global overrun");
    rd(4'd5, cw(1'b1, 1'b1, 10'h222), "R6 channel overrun");
    conv(3'd5, 10'h3FF);
    rd(4'd5, cw(1'b1, 1'b0, 10'h3FF), "R7 overrun clears after read");

    // R7 no overrun outside burst
    burst_en = 1'b0;
    conv(3'd1, 10'h0F0);
    conv(3'd1, 10'h00F);
    rd(4'd1, cw(1'b1, 1'b0, 10'h00F), "R7 no overrun without burst");

    // R10 enable register writes
    wr(4'd9, 32'h0000_01FF);
    rd(4'd10, 32'h0000_0100, "R10 write to other address ignored");
    wr(4'd10, 32'hFFFF_FE04);
    rd(4'd10, 32'h0000_0004, "R10 only enable bits stored");

    // R5 ctl_clr, R11 per-channel interrupt
    ctl_clr = 1'b1;
    tick();
    ctl_clr = 1'b0;
    rd(4'd8, gw(1'b0, 1'b0, 3'd1, 10'h00F), "R5 ctl_clr clears global done");
    conv(3'd1, 10'h055);
    tick();
    chk_bit(irq, 1'b0, "R11 disabled channel and global give no irq");
    conv(3'd2, 10'h0AA);
    tick();
    chk_bit(irq, 1'b1, "R11 enabled channel raises irq");
    rd(4'd9, 32'h0001_0006, "R9 interrupt flag bit 16");
    rd(4'd2, cw(1'b1, 1'b0, 10'h0AA), "R4 read enabled channel");
    tick();
    chk_bit(irq, 1'b0, "R11 irq drops after channel read");
    rd(4'd1, cw(1'b1, 1'b0, 10'h055), "R4 clear ch1");

    // R8 collision in burst mode
    burst_en = 1'b1;
    conv(3'd6, 10'h0AA);
    conv_and_rd(3'd6, 10'h155, cw(1'b1, 1'b0, 10'h0AA), "R8 read returns old contents");
    rd(4'd6, cw(1'b1, 1'b0, 10'h155), "R8 completion wins over read");
    rd(4'd6, cw(1'b0, 1'b0, 10'h155), "R8 then clears");

    // R5 global sample kept after ctl_clr
    conv(3'd0, 10'h001);
    ctl_clr = 1'b1;
    tick();
    ctl_clr = 1'b0;
    rd(4'd8, gw(1'b0, 1'b0, 3'd0, 10'h001), "R5 global cleared by ctl_clr");
    rd(4'd0, cw(1'b1, 1'b0, 10'h001), "R5 channel unaffected by ctl_clr");

    tick();
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover act=%0d exp=0", expq.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule